// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) over `W` clock cycles and returns the full `2W`-bit product. It uses one `W`-bit adder and no array of partial products. When a start request is accepted, the multiplicand is captured into a register that stays fixed for the whole operation. A single `2W`-bit register is loaded with zeros in its upper half and the multiplier in its lower half.

Each cycle, the block inspects bit 0 of that register. When the bit is 1, the multiplicand is added into the upper half. The whole register then moves one place to the right, and the adder's carry-out enters at the top. As product bits grow in from the top, the multiplier bits are consumed from the bottom, so the two together always fill exactly `2W` bits.

A client pulses the start input with both operands and waits for the one-cycle done pulse. It then reads the upper and lower halves of the product on two separate outputs. These outputs keep their value until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is active, and in the first cycle after it, busy and done are 0 and both product halves are 0.
- R2: A start request seen at a rising clock edge while busy is 0 is accepted, and busy reads 1 from that edge on.
- R3: When done is 1, the concatenation {prod_hi_o, prod_lo_o} equals the exact unsigned `2W`-bit product of the two operands captured at the accepted start. For example, with 4-bit operands, 6 times 5 gives 0001 1110.
- R4: Done is high for exactly one cycle. It rises at the `W`-th rising edge after the accepting edge, which is the same edge at which busy falls.
- R5: Busy stays 1 for exactly `W` cycles after an accepted start, one iteration per cycle, and it falls only together with a rising done.
- R6: A start request while busy is 1 is ignored. Busy continues, and the result still belongs to the operands captured at the earlier accepted start.
- R7: While busy is 0 and start is 0, both product halves hold their value, whatever the operand inputs do.
- R8: prod_hi_o carries product bits 2W-1 down to W, and prod_lo_o carries bits W-1 down to 0.
- R9: A start request presented in the cycle where done is 1 is accepted. A new operation then begins with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | W | Multiplicand operand, unsigned |
| mplier_i | input | W | Multiplier operand, unsigned |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: the product is complete |
| prod_hi_o | output | W | Upper half of the product |
| prod_lo_o | output | W | Lower half of the product |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle. While done is high, busy has already dropped, so a start request in that cycle reloads the product register at the next edge. The bench drives start with fresh operands in exactly the cycle where done is observed high. It then judges three things: the first product must already be correct in that done cycle, busy must return one cycle later, and the second product must match its own operands after a further `W` cycles. A second overlap, a start request raised in the middle of an operation, is checked by requiring an unchanged result and unchanged busy timing.

// File: rtl/shift_add_pkg.sv
package shift_add_pkg;

   // Selects how the W-bit accumulate adder is built.
   typedef enum int {
      ADD_INFER  = 0,
      ADD_RIPPLE = 1
   } adder_style_e;

endpackage

// File: rtl/shift_add_adder.sv
module shift_add_adder #(
   parameter int                          W     = 32,
   parameter shift_add_pkg::adder_style_e STYLE = shift_add_pkg::ADD_RIPPLE
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("shift_add_adder: W must be at least 1");
      end

      if (STYLE == shift_add_pkg::ADD_RIPPLE) begin : g_ripple
         logic [W:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
            assign carry[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & carry[i]) | (b_i[i] & carry[i]);
         end
         assign cout_o = carry[W];
      end else begin : g_infer
         logic [W:0] wide;
         assign wide   = {1'b0, a_i} + {1'b0, b_i};
         assign sum_o  = wide[W-1:0];
         assign cout_o = wide[W];
      end
   endgenerate

endmodule

// File: rtl/shift_add_iter_cnt.sv
module shift_add_iter_cnt #(
   parameter int STEPS = 32,
   localparam int CW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic last_o
);

   localparam logic [CW-1:0] LAST_VAL = CW'(STEPS - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (STEPS < 2) begin : g_bad_steps
         $error("shift_add_iter_cnt: STEPS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = step_i && (cnt_q == LAST_VAL);

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
   parameter int                          W         = 32,
   parameter shift_add_pkg::adder_style_e ADD_STYLE = shift_add_pkg::ADD_RIPPLE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] mcand_i,
   input  logic [W-1:0] mplier_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] prod_hi_o,
   output logic [W-1:0] prod_lo_o
);

   localparam int PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_w
         $error("shift_add_mult: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mcand_q;
   logic [PW-1:0] prod_q;
   logic          busy_q;
   logic          done_q;

   logic          accept;
   logic          last_step;
   logic [W-1:0]  addend;
   logic [W-1:0]  upper_sum;
   logic          upper_cout;

   assign accept = start_i && !busy_q;
   assign addend = prod_q[0] ? mcand_q : '0;

   shift_add_adder #(
      .W     (W),
      .STYLE (ADD_STYLE)
   ) adder_i (
      .a_i    (prod_q[PW-1:W]),
      .b_i    (addend),
      .sum_o  (upper_sum),
      .cout_o (upper_cout)
   );

   shift_add_iter_cnt #(
      .STEPS (W)
   ) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .step_i  (busy_q),
      .last_o  (last_step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         prod_q  <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            mcand_q <= mcand_i;
            prod_q  <= {{W{1'b0}}, mplier_i};
            busy_q  <= 1'b1;
         end else if (busy_q) begin
            prod_q <= {upper_cout, upper_sum, prod_q[W-1:1]};
            if (last_step) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign prod_hi_o = prod_q[PW-1:W];
   assign prod_lo_o = prod_q[W-1:0];

endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] prod_hi_o,
   input logic [W-1:0] prod_lo_o
);

   localparam int KW = $clog2(W + 1) + 1;

   logic [KW-1:0] busy_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cyc <= '0;
      end else if (start_i && !busy_o) begin
         busy_cyc <= '0;
      end else if (busy_o) begin
         busy_cyc <= busy_cyc + 1'b1;
      end
   end

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_cyc == KW'(W)));

   assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && (busy_cyc < KW'(W - 1))) |=> busy_o);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable({prod_hi_o, prod_lo_o}));

endmodule

bind shift_add_mult shift_add_mult_chk #(.W(W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .prod_hi_o (prod_hi_o),
   .prod_lo_o (prod_lo_o)
);

// File: tb/shift_add_mult_tb.sv
`timescale 1ns/1ps
module shift_add_mult_tb_top;

   localparam int W  = 32;
   localparam int NV = 8;

   localparam logic [W-1:0] TAB_A [NV] = '{
      32'd6, 32'd0, 32'hFFFF_FFFF, 32'd1,
      32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF};
   localparam logic [W-1:0] TAB_B [NV] = '{
      32'd5, 32'hCAFE_F00D, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
      32'd1, 32'd2, 32'h9ABC_DEF0, 32'd0};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] mcand_i = '0;
   logic [W-1:0] mplier_i = '0;
   logic         busy_o;
   logic         done_o;
   logic [W-1:0] prod_hi_o;
   logic [W-1:0] prod_lo_o;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   shift_add_mult #(.W(W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mcand_i   (mcand_i),
      .mplier_i  (mplier_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .prod_hi_o (prod_hi_o),
      .prod_lo_o (prod_lo_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] golden(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [63:0] wa, wb;
      wa = {32'd0, a};
      wb = {32'd0, b};
      return wa * wb;
   endfunction

   // Present start at a negedge; release after the next rising edge.
   task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      start_i  = 1'b1;
      mcand_i  = a;
      mplier_i = b;
      @(posedge clk);
      #1 start_i = 1'b0;
   endtask

   // Count negedges after the accepting edge until done is seen.
   task automatic wait_done(output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!done_o && k < 3 * W);
   endtask

   initial begin : watchdog
      #(4 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int k;
      logic [63:0] exp;
      logic [63:0] got;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o, "R1 flags in reset", {62'd0, busy_o, done_o}, 64'd0);
      check({prod_hi_o, prod_lo_o} == 64'd0, "R1 product in reset", {prod_hi_o, prod_lo_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && {prod_hi_o, prod_lo_o} == 64'd0, "R1 after release",
            {prod_hi_o, prod_lo_o}, 64'd0);

      // Vector table: R2, R3, R4, R5, R8
      for (int v = 0; v < NV; v++) begin
         exp = golden(TAB_A[v], TAB_B[v]);
         launch(TAB_A[v], TAB_B[v]);
         @(negedge clk);
         check(busy_o == 1'b1, "R2 busy after accept", {63'd0, busy_o}, 64'd1);
         k = 1;
         while (!done_o && k < 3 * W) begin
            @(negedge clk);
            k++;
         end
         check(k == W + 1, "R4/R5 done latency", 64'(k), 64'(W + 1));
         check(!busy_o, "R5 busy low at done", {63'd0, busy_o}, 64'd0);
         got = {prod_hi_o, prod_lo_o};
         check(got == exp, "R3 product", got, exp);
         check(prod_hi_o == exp[63:32] && prod_lo_o == exp[31:0], "R8 halves", got, exp);
         @(negedge clk);
         check(!done_o, "R4 single pulse", {63'd0, done_o}, 64'd0);
      end

      // R7: hold while idle, operand inputs toggling
      exp = golden(TAB_A[NV-1], TAB_B[NV-1]);
      for (int i = 0; i < 5; i++) begin
         mcand_i  = 32'h5555_0000 + 32'(i);
         mplier_i = 32'hAAAA_0000 + 32'(i);
         @(negedge clk);
      end
      got = {prod_hi_o, prod_lo_o};
      check(got == exp && !busy_o && !done_o, "R7 hold while idle", got, exp);

      // R6: start while busy is ignored
      exp = golden(32'h0000_0007, 32'h0001_0003);
      launch(32'h0000_0007, 32'h0001_0003);
      repeat (4) @(negedge clk);
      start_i  = 1'b1;
      mcand_i  = 32'hFFFF_0000;
      mplier_i = 32'h0F0F_0F0F;
      @(negedge clk);
      start_i = 1'b0;
      k = 5;
      while (!done_o && k < 3 * W) begin
         @(negedge clk);
         k++;
      end
      check(k == W + 1, "R6 timing unchanged", 64'(k), 64'(W + 1));
      got = {prod_hi_o, prod_lo_o};
      check(got == exp, "R6 result from first operands", got, exp);

      // R9: start in the done cycle (back-to-back)
      start_i  = 1'b1;
      mcand_i  = 32'd13;
      mplier_i = 32'd11;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1 && !done_o, "R9 accepted in done cycle", {62'd0, busy_o, done_o}, 64'd2);
      wait_done(k);
      check(k == W, "R9 second latency", 64'(k), 64'(W));
      got = {prod_hi_o, prod_lo_o};
      check(got == 64'd143, "R9 second product", got, 64'd143);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule